// File: doc/BRIEF.md
# Converter Conversion Timing Emulator

This block is a synthesizable, device-side stand-in for the digital side of a 12-bit sampling converter. Its purpose is to exercise host controllers. The host drives an active-low chip select, a read/convert line and a byte-select line. The block answers with a busy flag and a two-lane parallel data bus, plus an output-enable that takes the place of real tri-state pads. The analog value is replaced by a digital sample port, which is captured when a conversion starts.

A conversion starts when read/convert falls while chip select is low. Busy then drops for a fixed number of clock cycles. During the first part of that window the previous result can still be read. After that the bus carries a fixed poison pattern and a data-valid flag goes low, so an illegal read is visible to a testbench. When the conversion time has elapsed, the captured sample moves into the output register. Busy rises a short, fixed number of cycles later.

The byte-select line chooses how the 12-bit result is spread over the two 8-bit lanes, so a host can read the result either as one word or as two bytes.

Top module: `adc_timing_emu`

## Requirements
- R1: After reset, busy and data_valid are high, the output register holds zero, and with cs_n low and rc high the bus reads all zeros.
- R2: A start is accepted on the first rising clock edge that samples rc low, with cs_n low, rc high on the previous edge, and busy high. At that edge sample_in is captured and busy goes low.
- R3: Once a start is accepted, busy stays low for exactly CONV_CYC+BUSY_DLY clock edges and then rises.
- R4: CONV_CYC edges after the start, the captured sample is written to the output register. After busy rises, the bus shows that new result.
- R5: For the first HOLD_CYC edges after the start, data_valid stays high and the bus still shows the previous conversion's result.
- R6: From HOLD_CYC edges after the start until busy rises, data_valid is low. While bus_oe is high, bus_data equals the POISON parameter (default 16'hA5C3).
- R7: bus_oe is high only while cs_n is low and rc is high. While bus_oe is low, bus_data is all zeros.
- R8: With byte_sel low, bus_data[15:8] holds result bits 11..4, bus_data[7:4] holds result bits 3..0, and bus_data[3:0] is zero.
- R9: With byte_sel high, bus_data[15:12] holds result bits 3..0, bus_data[11:8] is zero, and bus_data[7:0] holds result bits 11..4.
- R10: A falling rc while busy is low is ignored. It neither restarts the timing nor replaces the captured sample.
- R11: A falling rc while cs_n is high starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rc | input | 1 | Read (high) / convert (falling edge) |
| byte_sel | input | 1 | Lane mapping select |
| sample_in | input | 12 | Value converted at start |
| busy | output | 1 | Low while a conversion is in progress |
| data_valid | output | 1 | Low while bus content is undefined |
| bus_oe | output | 1 | Bus drive enable |
| bus_data | output | 16 | Two 8-bit lanes, upper lane in [15:8] |

## Verification
All timing is counted in rising edges from the edge that accepts the start. The bench drives and samples only at falling edges, and counts edges since that start. Busy must be low at edge CONV_CYC+BUSY_DLY-1 and high at edge CONV_CYC+BUSY_DLY. The old result must still be valid at edge HOLD_CYC-1, and poison must appear at edge HOLD_CYC. The new result is checked once busy has risen. Output-enable and lane mapping are combinational, so they are checked in the same half cycle in which the pins change.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  typedef struct packed {
    logic cs_n;
    logic rc;
    logic byte_sel;
  } ctl_t;
endpackage

// File: rtl/adc_start_detect.sv
module adc_start_detect
  import adc_emu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl_i,
  output logic start_req_o
);
  logic rc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rc_q <= 1'b1;
    else        rc_q <= ctl_i.rc;
  end

  assign start_req_o = !ctl_i.cs_n && rc_q && !ctl_i.rc;

  a_r11_no_start_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.cs_n |-> !start_req_o);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DATA_W   = 12,
  parameter int CONV_CYC = 80,
  parameter int BUSY_DLY = 2,
  parameter int HOLD_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic              commit_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int TOTAL = CONV_CYC + BUSY_DLY;
  localparam int CW    = $clog2(TOTAL + 1);

  logic              busy_q;
  logic [CW-1:0]     el_q;
  logic [DATA_W-1:0] samp_q;
  logic [DATA_W-1:0] res_q;
  logic              accept;
  logic              last;

  assign accept   = busy_q && start_req_i;
  assign commit_o = !busy_q && (el_q == CW'(CONV_CYC - 1));
  assign last     = !busy_q && (el_q == CW'(TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      el_q   <= '0;
      samp_q <= '0;
      res_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b0;
      el_q   <= '0;
      samp_q <= sample_i;
    end else if (!busy_q) begin
      el_q <= el_q + 1'b1;
      if (commit_o) res_q  <= samp_q;
      if (last)     busy_q <= 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign valid_o  = busy_q || (el_q < CW'(HOLD_CYC));
  assign result_o = res_q;

  a_r2_start_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_req_i) |=> (!busy_o && samp_q == $past(sample_i)));
  a_r10_ignore_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_req_i) |=> $stable(samp_q));
  a_r4_commit_then_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (!busy_o && result_o == $past(samp_q)));
  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(el_q) == CW'(TOTAL - 1)));
  a_r4_result_frozen_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(result_o));
endmodule

// File: rtl/adc_lane_mux.sv
module adc_lane_mux
  import adc_emu_pkg::*;
#(
  parameter int          DATA_W = 12,
  parameter int          LANE_W = 8,
  parameter logic [2*LANE_W-1:0] POISON = 16'hA5C3
) (
  input  ctl_t              ctl_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              oe_o,
  output logic [2*LANE_W-1:0] data_o
);
  localparam int LO_W  = DATA_W - LANE_W;
  localparam int PAD_W = LANE_W - LO_W;

  function automatic logic [2*LANE_W-1:0] map_lanes(
    input logic [DATA_W-1:0] r, input logic sel);
    logic [LANE_W-1:0] hi_part, lo_part;
    hi_part = r[DATA_W-1 -: LANE_W];
    lo_part = {r[LO_W-1:0], {PAD_W{1'b0}}};
    return sel ? {lo_part, hi_part} : {hi_part, lo_part};
  endfunction

  assign oe_o = !ctl_i.cs_n && ctl_i.rc;

  always_comb begin
    if (!oe_o)         data_o = '0;
    else if (!valid_i) data_o = POISON;
    else               data_o = map_lanes(result_i, ctl_i.byte_sel);
  end
endmodule

// File: rtl/adc_timing_emu.sv
module adc_timing_emu
  import adc_emu_pkg::*;
#(
  parameter int          DATA_W   = 12,
  parameter int          LANE_W   = 8,
  parameter int          CONV_CYC = 80,
  parameter int          BUSY_DLY = 2,
  parameter int          HOLD_CYC = 40,
  parameter logic [15:0] POISON   = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rc,
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy,
  output logic              data_valid,
  output logic              bus_oe,
  output logic [2*LANE_W-1:0] bus_data
);
  ctl_t              ctl;
  logic              start_req;
  logic              commit;
  logic [DATA_W-1:0] result;

  assign ctl = '{cs_n: cs_n, rc: rc, byte_sel: byte_sel};

  adc_start_detect u_start (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .start_req_o(start_req));

  adc_conv_seq #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC),
                 .BUSY_DLY(BUSY_DLY), .HOLD_CYC(HOLD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req_i(start_req), .sample_i(sample_in),
    .busy_o(busy), .valid_o(data_valid), .commit_o(commit), .result_o(result));

  adc_lane_mux #(.DATA_W(DATA_W), .LANE_W(LANE_W),
                 .POISON(POISON[2*LANE_W-1:0])) u_mux (
    .ctl_i(ctl), .valid_i(data_valid), .result_i(result),
    .oe_o(bus_oe), .data_o(bus_data));

  a_r7_enable_pins: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!cs_n && rc));
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_data == '0));
  a_r6_poison_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !data_valid) |-> (bus_data == POISON[2*LANE_W-1:0]));
  a_r6_valid_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> data_valid);
endmodule

// File: tb/adc_timing_emu_test.sv
module adc_timing_emu_test;
  localparam int CLK_PERIOD = 10;
  localparam int CONV  = 80;
  localparam int DLY   = 2;
  localparam int HOLD  = 40;
  localparam int TOTAL = CONV + DLY;
  localparam logic [15:0] PSN = 16'hA5C3;

  logic clk = 0, rst_n = 0, cs_n = 0, rc = 1, byte_sel = 0;
  logic [11:0] sample_in = '0;
  logic busy, data_valid, bus_oe;
  logic [15:0] bus_data;
  int errors = 0, checks = 0, j = 0;
  bit done = 0;
  logic [11:0] prev_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_timing_emu #(.CONV_CYC(CONV), .BUSY_DLY(DLY), .HOLD_CYC(HOLD), .POISON(PSN)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc(rc), .byte_sel(byte_sel),
    .sample_in(sample_in), .busy(busy), .data_valid(data_valid),
    .bus_oe(bus_oe), .bus_data(bus_data));

  function automatic logic [15:0] exp_bus(input logic [11:0] r, input logic sel);
    logic [15:0] up, lo;
    up = 16'(r >> 4);
    lo = 16'(r & 12'hF);
    return sel ? ((lo << 12) | up) : ((up << 8) | (lo << 4));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); j++; end
  endtask

  task automatic start_conv(input logic [11:0] s);
    sample_in = s; rc = 0;
    tick(1);
    rc = 1; j = 0;
    chk("R2 busy low after start", 16'(busy), 16'h0);
  endtask

  task automatic run_conv(input logic [11:0] s, input logic sel, input bit poke);
    byte_sel = sel;
    start_conv(s);
    if (poke) begin
      tick(10 - j);
      rc = 0; sample_in = 12'h123;
      tick(1);
      rc = 1;
    end
    tick(HOLD - 1 - j);
    chk("R5 old data valid", 16'(data_valid), 16'h1);
    chk("R5 old data on bus", bus_data, exp_bus(prev_res, sel));
    tick(1);
    chk("R6 data invalid", 16'(data_valid), 16'h0);
    chk("R6 poison on bus", bus_data, PSN);
    tick(TOTAL - 1 - j);
    chk("R3 busy still low", 16'(busy), 16'h0);
    chk("R6 poison until busy", bus_data, PSN);
    tick(1);
    chk(poke ? "R10 busy rise timing unchanged" : "R3 busy rises", 16'(busy), 16'h1);
    chk(sel ? "R9 R4 new result" : "R8 R4 new result", bus_data, exp_bus(s, sel));
    prev_res = s;
    byte_sel = !sel;
    #1 chk(sel ? "R8 remap" : "R9 remap", bus_data, exp_bus(s, !sel));
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", 16'(busy), 16'h1);
    chk("R1 valid", 16'(data_valid), 16'h1);
    chk("R1 oe", 16'(bus_oe), 16'h1);
    chk("R1 zero result", bus_data, 16'h0);
    cs_n = 1;
    #1 chk("R7 oe off cs high", 16'(bus_oe), 16'h0);
    chk("R7 bus zero", bus_data, 16'h0);
    rc = 0;
    tick(2);
    chk("R11 no start cs high", 16'(busy), 16'h1);
    chk("R7 oe off rc low", 16'(bus_oe), 16'h0);
    rc = 1;
    tick(1);
    cs_n = 0;
    tick(1);
    run_conv(12'hABC, 0, 1);
    run_conv(12'h000, 1, 0);
    run_conv(12'hFFF, 0, 0);
    run_conv(12'h801, 1, 0);
    for (int k = 0; k < 12; k++)
      run_conv(12'($urandom), 1'($urandom), k[0]);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule